// File: doc/BRIEF.md
# Transactional Access-Set Conflict Tracker

This block follows the memory footprint of one hardware transaction on a single core. Begin and end pulses mark the start and finish of a transaction. While a transaction runs, every local load adds its cache line to the read set and every local store adds its line to the write set. Both sets share a small fully associative table of line tags. Each entry records which 8-byte words of the line were read and which were written.

Remote reads and writes arrive on a snoop channel. Each one is compared against the table in the cycle it arrives. Any of the following ends the transaction: a collision with the sets, a ninth distinct line, an interrupt, or a software abort request. The block then raises a one-cycle abort pulse and presents a two-bit reason code. The code stays valid until the next transaction begins. A clean end raises a one-cycle commit pulse. In both cases the sets are emptied.

A mode input selects the conflict granularity. In line mode, any overlap inside a 64-byte line is a conflict. In word mode, only accesses to the same 8-byte word conflict, so false sharing between neighbouring words is tolerated.

Top module: `txn_conflict_tracker`

## Requirements
- R1: After reset the tracker is idle (`tx_active`=0, both pulses 0, `abort_reason`=2'b00). A `tx_begin` pulse while idle sets `tx_active` on the next clock edge. A `tx_begin` while active is ignored, and so is a `tx_end` while idle.
- R2: In line mode (`word_mode`=0), consider a remote read or write whose line (address bits [31:6]) holds a word written by the transaction. It raises `abort_pulse` one cycle after the snoop with `abort_reason`=2'b00, even when the words differ.
- R3: A remote write to a line in the read set aborts with reason 2'b00. A remote read to a line that was only read does not abort.
- R4: In word mode (`word_mode`=1), a snoop conflicts only if it touches the same word (address bits [5:3]) that was read (for a remote write) or written (for any remote access). Other words of the same line cause no abort.
- R5: The table holds 8 lines. An access to a ninth distinct line aborts with reason 2'b01 (overflow). A repeated access to a tracked line never overflows.
- R6: `irq` during a transaction aborts with reason 2'b10. `sw_abort` during a transaction aborts with reason 2'b11.
- R7: When several abort causes occur in one cycle, the reason follows this priority: interrupt 2'b10, then conflict 2'b00, then overflow 2'b01, then software 2'b11.
- R8: `tx_end` during a transaction with no abort cause in that cycle gives a one-cycle `commit_pulse` and returns to idle. The sets are emptied, so a later transaction does not conflict on the earlier lines.
- R9: `abort_reason` is held while idle until the next `tx_begin`, which sets it back to 2'b00.
- R10: Local accesses while idle are ignored and leave nothing in the sets.
- R11: A snoop is compared against the sets as they stood before any local access in the same cycle. `abort_pulse` is one cycle wide and the tracker is idle while it is high.
- R12: When an abort cause and `tx_end` coincide, the abort wins and no `commit_pulse` is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_mode | input | 1 | 0: line granularity, 1: word granularity |
| tx_begin | input | 1 | Start-of-transaction pulse |
| tx_end | input | 1 | End-of-transaction pulse |
| sw_abort | input | 1 | Software abort request |
| irq | input | 1 | External interrupt |
| acc_valid | input | 1 | Local access valid |
| acc_write | input | 1 | Local access is a store |
| acc_addr | input | 32 | Local access byte address |
| snp_valid | input | 1 | Remote access valid |
| snp_write | input | 1 | Remote access is a write |
| snp_addr | input | 32 | Remote access byte address |
| tx_active | output | 1 | Transaction running |
| abort_pulse | output | 1 | One-cycle abort indication |
| abort_reason | output | 2 | 00 conflict, 01 overflow, 10 interrupt, 11 software |
| commit_pulse | output | 1 | One-cycle successful end |

## Verification
The assertions assume three things about the inputs: each local access touches a single aligned 8-byte word, at most one local access arrives per cycle, and `word_mode` is held steady for the whole transaction. The random stimulus respects all three. It builds addresses from a tag in the range 0 to 11 and a word index, places each access on its own cycle, and changes the mode only between directed and random phases while the tracker is idle. The tag range of twelve lines against eight entries makes overflow, hits on tracked lines and collisions on shared lines all frequent.

// File: rtl/txc_pkg.sv
// Shared definitions for the transactional conflict tracker.
// Assumes: the abort reason is a two-bit code that software decodes.
package txc_pkg;

    typedef enum logic [1:0] {
        RSN_CONFLICT = 2'b00,
        RSN_OVERFLOW = 2'b01,
        RSN_IRQ      = 2'b10,
        RSN_SOFT     = 2'b11
    } abort_rsn_e;

    // Fixed priority: interrupt, conflict, overflow, software request.
    function automatic abort_rsn_e pick_reason(input logic irq, input logic conf,
                                               input logic ovf);
        if (irq)       return RSN_IRQ;
        else if (conf) return RSN_CONFLICT;
        else if (ovf)  return RSN_OVERFLOW;
        else           return RSN_SOFT;
    endfunction

endpackage

// File: rtl/txc_entry_cmp.sv
// Per-entry comparator: reports a tag hit for the local access and a
// conflict for the snoop. Assumes that the masks mark touched words and that
// snp_word is one-hot.
module txc_entry_cmp #(
    parameter int TAG_W = 26,
    parameter int WORDS = 8
) (
    input  logic             vld,
    input  logic [TAG_W-1:0] tag,
    input  logic [WORDS-1:0] rmask,
    input  logic [WORDS-1:0] wmask,
    input  logic [TAG_W-1:0] acc_tag,
    input  logic [TAG_W-1:0] snp_tag,
    input  logic [WORDS-1:0] snp_word,
    input  logic             snp_write,
    input  logic             word_mode,
    output logic             acc_hit,
    output logic             snp_conf
);

    logic rd_touch;
    logic wr_touch;

    // Overlap test at line or word granularity.
    always_comb begin
        rd_touch = word_mode ? |(rmask & snp_word) : |rmask;
        wr_touch = word_mode ? |(wmask & snp_word) : |wmask;
    end

    // Hit and conflict decisions for this entry.
    always_comb begin
        acc_hit  = vld && (tag == acc_tag);
        snp_conf = vld && (tag == snp_tag) && ((snp_write && rd_touch) || wr_touch);
    end

endmodule

// File: rtl/txc_set_table.sv
// Fully associative read/write-set table. Each entry keeps a line tag and
// per-word read and write masks. Assumes at most one local access per cycle
// and that clear takes precedence over any update.
module txc_set_table #(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 26,
    parameter int WORDS   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             word_mode,
    input  logic             acc_en,
    input  logic             acc_write,
    input  logic [TAG_W-1:0] acc_tag,
    input  logic [WORDS-1:0] acc_word,
    input  logic             snp_en,
    input  logic             snp_write,
    input  logic [TAG_W-1:0] snp_tag,
    input  logic [WORDS-1:0] snp_word,
    output logic             overflow,
    output logic             conflict
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] vld_q;
    logic [TAG_W-1:0]   tag_q   [ENTRIES];
    logic [WORDS-1:0]   rmask_q [ENTRIES];
    logic [WORDS-1:0]   wmask_q [ENTRIES];
    logic [ENTRIES-1:0] acc_hit;
    logic [ENTRIES-1:0] snp_hit;
    logic [IDX_W-1:0]   free_idx;
    logic               any_free;
    logic               hit_any;

    // One comparator per entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        txc_entry_cmp #(.TAG_W(TAG_W), .WORDS(WORDS)) u_cmp (
            .vld       (vld_q[g]),
            .tag       (tag_q[g]),
            .rmask     (rmask_q[g]),
            .wmask     (wmask_q[g]),
            .acc_tag   (acc_tag),
            .snp_tag   (snp_tag),
            .snp_word  (snp_word),
            .snp_write (snp_write),
            .word_mode (word_mode),
            .acc_hit   (acc_hit[g]),
            .snp_conf  (snp_hit[g])
        );
    end

    // Lowest free slot for allocation.
    always_comb begin
        free_idx = '0;
        any_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld_q[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
    end

    // Capacity and collision flags.
    always_comb begin
        hit_any  = |acc_hit;
        overflow = acc_en && !hit_any && !any_free;
        conflict = snp_en && (|snp_hit);
    end

    // Entry storage: clear, merge a hit, or allocate a fresh line.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            vld_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                tag_q[i]   <= '0;
                rmask_q[i] <= '0;
                wmask_q[i] <= '0;
            end
        end else if (acc_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (acc_hit[i]) begin
                    if (acc_write) wmask_q[i] <= wmask_q[i] | acc_word;
                    else           rmask_q[i] <= rmask_q[i] | acc_word;
                end else if (!hit_any && any_free && (free_idx == IDX_W'(i))) begin
                    vld_q[i]   <= 1'b1;
                    tag_q[i]   <= acc_tag;
                    rmask_q[i] <= acc_write ? '0 : acc_word;
                    wmask_q[i] <= acc_write ? acc_word : '0;
                end
            end
        end
    end

    AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(acc_hit)); // R5
    AST_OVF_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (&vld_q)); // R5
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (vld_q == '0)); // R8

endmodule

// File: rtl/txc_ctrl.sv
// Transaction state and outcome control. Turns the abort causes into a
// registered abort pulse and a held reason code, and a clean end into a
// commit pulse. Assumes the causes are already qualified as combinational
// flags for the current cycle.
module txc_ctrl
    import txc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_begin,
    input  logic       tx_end,
    input  logic       sw_abort,
    input  logic       irq,
    input  logic       conflict,
    input  logic       overflow,
    output logic       active,
    output logic       clear,
    output logic       abort_pulse,
    output logic [1:0] abort_reason,
    output logic       commit_pulse
);

    logic       abort_now;
    logic       commit_now;
    abort_rsn_e rsn_q;

    // Decide this cycle's outcome.
    always_comb begin
        abort_now  = active && (irq || conflict || overflow || sw_abort);
        commit_now = active && tx_end && !abort_now;
        clear      = !active || abort_now || commit_now;
    end

    // State, pulses and the held reason code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active       <= 1'b0;
            abort_pulse  <= 1'b0;
            commit_pulse <= 1'b0;
            rsn_q        <= RSN_CONFLICT;
        end else begin
            abort_pulse  <= abort_now;
            commit_pulse <= commit_now;
            if (abort_now) begin
                active <= 1'b0;
                rsn_q  <= pick_reason(irq, conflict, overflow);
            end else if (commit_now) begin
                active <= 1'b0;
            end else if (!active && tx_begin) begin
                active <= 1'b1;
                rsn_q  <= RSN_CONFLICT;
            end
        end
    end

    assign abort_reason = rsn_q;

    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(abort_pulse && commit_pulse)); // R12
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> !active); // R11
    AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |=> !abort_pulse); // R11
    AST_REASON_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !tx_begin) |=> $stable(abort_reason)); // R9
    AST_IRQ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (active && irq) |=> (abort_pulse && abort_reason == 2'b10)); // R7
    AST_BEGIN_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && tx_begin) |=> (active && abort_reason == 2'b00)); // R1

endmodule

// File: rtl/txn_conflict_tracker.sv
// Top of the transactional conflict tracker. Splits addresses into line tag
// and word index, gates local and remote traffic by the transaction state,
// and joins the set table with the outcome control. Assumes each access is
// confined to one aligned word and there is one local access per cycle.
module txn_conflict_tracker #(
    parameter int ADDR_W   = 32,
    parameter int ENTRIES  = 8,
    parameter int LINE_OFF = 6,
    parameter int WORD_OFF = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_mode,
    input  logic              tx_begin,
    input  logic              tx_end,
    input  logic              sw_abort,
    input  logic              irq,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              snp_valid,
    input  logic              snp_write,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              tx_active,
    output logic              abort_pulse,
    output logic [1:0]        abort_reason,
    output logic              commit_pulse
);

    localparam int TAG_W = ADDR_W - LINE_OFF;
    localparam int IDX_B = LINE_OFF - WORD_OFF;
    localparam int WORDS = 1 << IDX_B;

    logic             active;
    logic             clear;
    logic             overflow;
    logic             conflict;
    logic             acc_en;
    logic             snp_en;
    logic [WORDS-1:0] acc_word;
    logic [WORDS-1:0] snp_word;

    // Qualify traffic by state and decode word positions.
    always_comb begin
        acc_en   = active && acc_valid;
        snp_en   = active && snp_valid;
        acc_word = WORDS'(1) << acc_addr[LINE_OFF-1:WORD_OFF];
        snp_word = WORDS'(1) << snp_addr[LINE_OFF-1:WORD_OFF];
    end

    txc_set_table #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .WORDS(WORDS)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .word_mode (word_mode),
        .acc_en    (acc_en),
        .acc_write (acc_write),
        .acc_tag   (acc_addr[ADDR_W-1:LINE_OFF]),
        .acc_word  (acc_word),
        .snp_en    (snp_en),
        .snp_write (snp_write),
        .snp_tag   (snp_addr[ADDR_W-1:LINE_OFF]),
        .snp_word  (snp_word),
        .overflow  (overflow),
        .conflict  (conflict)
    );

    txc_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_begin     (tx_begin),
        .tx_end       (tx_end),
        .sw_abort     (sw_abort),
        .irq          (irq),
        .conflict     (conflict),
        .overflow     (overflow),
        .active       (active),
        .clear        (clear),
        .abort_pulse  (abort_pulse),
        .abort_reason (abort_reason),
        .commit_pulse (commit_pulse)
    );

    assign tx_active = active;

    AST_IDLE_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |=> !abort_pulse); // R10
    AST_END_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && tx_end && !irq && !sw_abort && !snp_valid && !acc_valid)
        |=> commit_pulse); // R8

endmodule

// File: tb/test_txn_conflict_tracker.sv
module test_txn_conflict_tracker;

    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic word_mode = 1'b0;
    logic tx_begin = 0, tx_end = 0, sw_abort = 0, irq = 0;
    logic acc_valid = 0, acc_write = 0, snp_valid = 0, snp_write = 0;
    logic [31:0] acc_addr = '0, snp_addr = '0;
    logic tx_active, abort_pulse, commit_pulse;
    logic [1:0] abort_reason;

    int n_chk = 0;
    int n_fail = 0;
    string cur_req = "R1";

    // Reference state built from the requirements.
    logic        m_act = 0;
    logic [1:0]  m_rsn = 0;
    logic        m_v [8];
    logic [25:0] m_t [8];
    logic [7:0]  m_r [8];
    logic [7:0]  m_w [8];
    logic        exp_ab, exp_cm;

    always #(CLK_P/2) clk = ~clk;

    txn_conflict_tracker i_txn_conflict_tracker (
        .clk(clk), .rst_n(rst_n), .word_mode(word_mode),
        .tx_begin(tx_begin), .tx_end(tx_end), .sw_abort(sw_abort), .irq(irq),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .snp_valid(snp_valid), .snp_write(snp_write), .snp_addr(snp_addr),
        .tx_active(tx_active), .abort_pulse(abort_pulse),
        .abort_reason(abort_reason), .commit_pulse(commit_pulse)
    );

    function automatic logic [31:0] mk(input int tag, input int word);
        return {26'(tag), 3'(word), 3'b000};
    endfunction

    task automatic m_clear();
        for (int i = 0; i < 8; i++) begin
            m_v[i] = 0; m_t[i] = 0; m_r[i] = 0; m_w[i] = 0;
        end
    endtask

    // Advance the reference by one clock edge.
    task automatic model();
        logic conf, ovf, ab, orr, oww;
        logic [7:0] wd;
        int hit, free, cnt;
        conf = 0; hit = -1; free = -1; cnt = 0;
        wd = 8'b1 << snp_addr[5:3];
        for (int i = 0; i < 8; i++) begin
            if (m_act && snp_valid && m_v[i] && m_t[i] == snp_addr[31:6]) begin
                orr = word_mode ? |(m_r[i] & wd) : |m_r[i];
                oww = word_mode ? |(m_w[i] & wd) : |m_w[i];
                if ((snp_write && orr) || oww) conf = 1;
            end
            if (m_v[i]) begin
                cnt++;
                if (m_t[i] == acc_addr[31:6]) hit = i;
            end else if (free < 0) free = i;
        end
        ovf = m_act && acc_valid && hit < 0 && cnt == 8;
        ab = m_act && (irq || conf || ovf || sw_abort);
        exp_ab = 0; exp_cm = 0;
        if (ab) begin
            exp_ab = 1; m_act = 0; m_clear();
            m_rsn = irq ? 2'b10 : conf ? 2'b00 : ovf ? 2'b01 : 2'b11;
        end else if (m_act && tx_end) begin
            exp_cm = 1; m_act = 0; m_clear();
        end else if (!m_act) begin
            if (tx_begin) begin m_act = 1; m_rsn = 2'b00; end
            m_clear();
        end else if (acc_valid) begin
            wd = 8'b1 << acc_addr[5:3];
            if (hit < 0) begin
                hit = free; m_v[hit] = 1; m_t[hit] = acc_addr[31:6];
                m_r[hit] = 0; m_w[hit] = 0;
            end
            if (acc_write) m_w[hit] = m_w[hit] | wd;
            else           m_r[hit] = m_r[hit] | wd;
        end
    endtask

    task automatic check();
        n_chk++;
        if ({tx_active, abort_pulse, commit_pulse, abort_reason} !==
            {m_act, exp_ab, exp_cm, m_rsn}) begin
            n_fail++;
            $display("FAIL %s: act/abort/commit/rsn got %b/%b/%b/%b exp %b/%b/%b/%b",
                     cur_req, tx_active, abort_pulse, commit_pulse, abort_reason,
                     m_act, exp_ab, exp_cm, m_rsn);
        end
    endtask

    // Apply one cycle of stimulus, then compare after the edge.
    task automatic cyc(input logic b, input logic e, input logic sa, input logic iq,
                       input logic av, input logic aw, input logic [31:0] aa,
                       input logic sv, input logic sw, input logic [31:0] sd);
        @(negedge clk);
        tx_begin = b; tx_end = e; sw_abort = sa; irq = iq;
        acc_valid = av; acc_write = aw; acc_addr = aa;
        snp_valid = sv; snp_write = sw; snp_addr = sd;
        model();
        @(posedge clk); #1;
        check();
    endtask

    task automatic idle();     cyc(0,0,0,0, 0,0,0, 0,0,0); endtask
    task automatic beg();      cyc(1,0,0,0, 0,0,0, 0,0,0); endtask
    task automatic fin();      cyc(0,1,0,0, 0,0,0, 0,0,0); endtask
    task automatic ld(input int t, input int w); cyc(0,0,0,0, 1,0,mk(t,w), 0,0,0); endtask
    task automatic st(input int t, input int w); cyc(0,0,0,0, 1,1,mk(t,w), 0,0,0); endtask
    task automatic snp(input logic wr, input int t, input int w);
        cyc(0,0,0,0, 0,0,0, 1,wr,mk(t,w));
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, got hang exp completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        m_clear();
        void'($urandom(32'h5eed));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        @(posedge clk); #1;
        cur_req = "R1 reset"; exp_ab = 0; exp_cm = 0; check();

        cur_req = "R1"; beg(); beg(); fin(); fin(); idle();
        cur_req = "R2"; beg(); st(5,0); snp(0,5,3); idle();
        cur_req = "R3"; beg(); ld(6,1); snp(0,6,1); snp(1,6,4); idle();
        cur_req = "R4"; word_mode = 1; beg(); st(7,2); ld(7,5); snp(1,7,3);
        snp(0,7,5); snp(0,7,2); word_mode = 0; idle();
        cur_req = "R5"; beg();
        for (int t = 0; t < 8; t++) ld(t, t);
        ld(3,6); st(3,0); ld(8,0); idle();
        cur_req = "R6"; beg(); cyc(0,0,0,1, 0,0,0, 0,0,0);
        beg(); cyc(0,0,1,0, 0,0,0, 0,0,0);
        cur_req = "R9"; idle(); idle(); beg();
        cur_req = "R7"; st(1,0); cyc(0,0,1,1, 0,0,0, 1,1,mk(1,0));
        beg(); st(1,0); cyc(0,0,1,0, 0,0,0, 1,1,mk(1,0));
        beg();
        for (int t = 0; t < 8; t++) st(t, 1);
        cyc(0,0,1,0, 1,0,mk(9,0), 0,0,0);
        cur_req = "R8"; beg(); st(2,0); fin(); beg(); snp(1,2,0); fin();
        cur_req = "R10"; st(4,0); beg(); snp(1,4,0); fin();
        cur_req = "R11"; beg(); cyc(0,0,0,0, 1,1,mk(9,0), 1,0,mk(9,0));
        snp(0,9,0); idle();
        cur_req = "R12"; beg(); st(1,0); cyc(0,1,0,0, 0,0,0, 1,1,mk(1,0)); idle();

        cur_req = "R2-random";
        for (int n = 0; n < 4000; n++) begin
            logic b, e, sa, iq, av, aw, sv, sw;
            if (n == 2000) begin
                while (m_act) fin();
                word_mode = 1; cur_req = "R4-random";
            end
            b  = !m_act && ($urandom % 3 == 0);
            e  = m_act && ($urandom % 20 == 0);
            iq = m_act && ($urandom % 200 == 0);
            sa = m_act && ($urandom % 200 == 0);
            av = ($urandom % 2 == 0);
            aw = ($urandom % 2 == 0);
            sv = ($urandom % 4 == 0);
            sw = ($urandom % 2 == 0);
            cyc(b, e, sa, iq, av, aw, mk($urandom % 12, $urandom % 8),
                sv, sw, mk($urandom % 12, $urandom % 8));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule